// File: doc/BRIEF.md
# Profiling Register Access Permission Gate

This block decides what happens when software reads or writes a protected profiling counter register. It looks at the privilege level of the access, whether the hypervisor and monitor levels exist and run in 64-bit mode, a hypervisor trap control, the security state, a two-bit control that names which security state owns the profiling unit, and a three-bit nested-virtualization control. From these it picks exactly one outcome: the access is undefined, it traps to the hypervisor level, it traps to the monitor level, it is sent to a memory slot at a fixed offset, or it reaches the register directly.

The decision is an ordered chain rather than a plain comparison of levels. At the lowest privileged level, the hypervisor trap is checked first. The monitor ownership check comes next. The memory redirect is tested last. Reads and writes follow the same chain. A write only turns into a register store or a memory store according to the outcome.

A registered wrapper samples all inputs on a request strobe. One cycle later it presents the outcome, the trap syndrome class, the redirect offset and the write strobes, together with a one-cycle valid pulse. Carrying out the trap and performing the memory access are left to the surrounding logic.

Top module: `priv_acc_gate`

## Requirements
- R1: An access at privilege level 0 always yields outcome undefined (code 1), whatever the other inputs are.
- R2: At level 1, when `l2_on64` and `hyp_trap` are both 1, the outcome is trap-to-level-2 (code 2), taking priority over the owner check and the redirect.
- R3: At levels 1 and 2, when no earlier check applies and `l3_on64` is 1, the access traps to level 3 (code 3) if `nonsecure` is 0 and `owner_ctl` is not 2'b01, or if `nonsecure` is 1 and `owner_ctl` is not 2'b11.
- R4: At level 1, when neither trap applies, `l2_on64` is 1 and `nv_ctl[2]` and `nv_ctl[0]` are both 1 (`nv_ctl[1]` is ignored), the outcome is memory redirect (code 4) with `rsp_mem_off` equal to 12'h838; otherwise the outcome is direct (code 0).
- R5: At level 2, `hyp_trap` and `nv_ctl` have no effect; an access that does not trap to level 3 is direct.
- R6: At level 3, every access is direct.
- R7: `rsp_class` is 6'h18 for both trap outcomes and 0 for all others; `rsp_mem_off` is 0 unless the outcome is redirect.
- R8: `rsp_valid` is high for exactly the one cycle that follows each cycle in which `req_valid` is high, and is low otherwise; back-to-back requests give back-to-back responses.
- R9: `rsp_reg_wr` is high only with a valid direct write and `rsp_mem_wr` only with a valid redirected write; a read raises neither, and both strobes follow the same decision as a read would.
- R10: While `rst` is high, and in the first cycle after it, `rsp_valid`, `rsp_kind`, `rsp_class`, `rsp_mem_off` and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; inputs are sampled when high |
| req_write | input | 1 | 1 = write access, 0 = read access |
| priv_lvl | input | 2 | Privilege level of the access, 0 to 3 |
| l2_on64 | input | 1 | Level 2 is present, enabled and in 64-bit mode |
| l3_on64 | input | 1 | Level 3 is present and in 64-bit mode |
| hyp_trap | input | 1 | Hypervisor trap control for the profiling registers |
| nonsecure | input | 1 | 1 = non-secure state, 0 = secure state |
| owner_ctl | input | 2 | Monitor-level owner control of the profiling unit |
| nv_ctl | input | 3 | Nested-virtualization control, bit 2 down to bit 0 |
| rsp_valid | output | 1 | One-cycle pulse marking a new outcome |
| rsp_kind | output | 3 | Outcome: 0 direct, 1 undefined, 2 trap L2, 3 trap L3, 4 redirect |
| rsp_class | output | 6 | Syndrome class for the trap outcomes, else 0 |
| rsp_mem_off | output | 12 | Memory offset for the redirect outcome, else 0 |
| rsp_reg_wr | output | 1 | Write goes to the register |
| rsp_mem_wr | output | 1 | Write goes to the redirect memory slot |

## Verification
The bench builds the gate with its default parameters: a 6-bit class of 0x18, a 12-bit offset of 0x838, and owner grant codes 01 for secure and 11 for non-secure. With these values the whole input space is only 4096 request combinations. The bench therefore drives every combination of level, presence flags, trap bit, security state, owner code, virtualization code and direction as one back-to-back stream. That covers every priority collision in the chain, for example a hypervisor trap meeting a failing owner check, or a redirect pattern at level 2. Short idle gaps between bursts show that responses appear only for real requests.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

  typedef enum logic [2:0] {
    ACC_DIRECT   = 3'd0,
    ACC_UNDEF    = 3'd1,
    ACC_TRAP_HYP = 3'd2,
    ACC_TRAP_MON = 3'd3,
    ACC_REDIRECT = 3'd4
  } acc_kind_e;

  localparam int LVL_W   = 2;
  localparam int OWNER_W = 2;
  localparam int NV_W    = 3;

endpackage

// File: rtl/pacc_owner_chk.sv
module pacc_owner_chk #(
  parameter int                 OWN_W     = 2,
  parameter logic [OWN_W-1:0]   SEC_GRANT = 2'b01,
  parameter logic [OWN_W-1:0]   NS_GRANT  = 2'b11
) (
  input  logic             l3_on64,
  input  logic             nonsecure,
  input  logic [OWN_W-1:0] owner_ctl,
  output logic             deny
);

  logic granted;

  // The owner code that lets the lower levels in depends on security state.
  always_comb begin
    if (nonsecure) granted = (owner_ctl == NS_GRANT);
    else           granted = (owner_ctl == SEC_GRANT);
    deny = l3_on64 & ~granted;
  end

endmodule

// File: rtl/pacc_decide.sv
module pacc_decide
  import pacc_pkg::*;
#(
  parameter int                 CLASS_W    = 6,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18,
  parameter int                 OFF_W      = 12,
  parameter logic [OFF_W-1:0]   REDIR_OFF  = 12'h838
) (
  input  logic [LVL_W-1:0]   priv_lvl,
  input  logic               l2_on64,
  input  logic               l3_on64,
  input  logic               hyp_trap,
  input  logic               nonsecure,
  input  logic [OWNER_W-1:0] owner_ctl,
  input  logic [NV_W-1:0]    nv_ctl,
  output acc_kind_e          kind,
  output logic [CLASS_W-1:0] cls,
  output logic [OFF_W-1:0]   off
);

  logic mon_deny;
  logic hyp_hit;
  logic nv_hit;

  pacc_owner_chk #(
    .OWN_W    (OWNER_W),
    .SEC_GRANT(2'b01),
    .NS_GRANT (2'b11)
  ) u_owner (
    .l3_on64  (l3_on64),
    .nonsecure(nonsecure),
    .owner_ctl(owner_ctl),
    .deny     (mon_deny)
  );

  // Redirect pattern: top and bottom bits set, middle bit don't-care.
  assign nv_hit  = l2_on64 & nv_ctl[NV_W-1] & nv_ctl[0];
  assign hyp_hit = l2_on64 & hyp_trap;

  // Ordered chain: per level, earliest matching rule wins.
  always_comb begin
    kind = ACC_DIRECT;
    unique case (priv_lvl)
      2'd0: kind = ACC_UNDEF;
      2'd1: begin
        if (hyp_hit)       kind = ACC_TRAP_HYP;
        else if (mon_deny) kind = ACC_TRAP_MON;
        else if (nv_hit)   kind = ACC_REDIRECT;
        else               kind = ACC_DIRECT;
      end
      2'd2: begin
        if (mon_deny) kind = ACC_TRAP_MON;
        else          kind = ACC_DIRECT;
      end
      default: kind = ACC_DIRECT;
    endcase
  end

  always_comb begin
    cls = '0;
    off = '0;
    if (kind == ACC_TRAP_HYP || kind == ACC_TRAP_MON) cls = TRAP_CLASS;
    if (kind == ACC_REDIRECT)                         off = REDIR_OFF;
  end

endmodule

// File: rtl/priv_acc_gate.sv
module priv_acc_gate
  import pacc_pkg::*;
#(
  parameter int                 CLASS_W    = 6,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18,
  parameter int                 OFF_W      = 12,
  parameter logic [OFF_W-1:0]   REDIR_OFF  = 12'h838
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         priv_lvl,
  input  logic               l2_on64,
  input  logic               l3_on64,
  input  logic               hyp_trap,
  input  logic               nonsecure,
  input  logic [1:0]         owner_ctl,
  input  logic [2:0]         nv_ctl,
  output logic               rsp_valid,
  output logic [2:0]         rsp_kind,
  output logic [CLASS_W-1:0] rsp_class,
  output logic [OFF_W-1:0]   rsp_mem_off,
  output logic               rsp_reg_wr,
  output logic               rsp_mem_wr
);

  acc_kind_e          d_kind;
  logic [CLASS_W-1:0] d_cls;
  logic [OFF_W-1:0]   d_off;

  pacc_decide #(
    .CLASS_W   (CLASS_W),
    .TRAP_CLASS(TRAP_CLASS),
    .OFF_W     (OFF_W),
    .REDIR_OFF (REDIR_OFF)
  ) u_decide (
    .priv_lvl (priv_lvl),
    .l2_on64  (l2_on64),
    .l3_on64  (l3_on64),
    .hyp_trap (hyp_trap),
    .nonsecure(nonsecure),
    .owner_ctl(owner_ctl),
    .nv_ctl   (nv_ctl),
    .kind     (d_kind),
    .cls      (d_cls),
    .off      (d_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_kind    <= 3'd0;
      rsp_class   <= '0;
      rsp_mem_off <= '0;
      rsp_reg_wr  <= 1'b0;
      rsp_mem_wr  <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_reg_wr <= req_valid & req_write & (d_kind == ACC_DIRECT);
      rsp_mem_wr <= req_valid & req_write & (d_kind == ACC_REDIRECT);
      if (req_valid) begin
        rsp_kind    <= d_kind;
        rsp_class   <= d_cls;
        rsp_mem_off <= d_off;
      end
    end
  end

  AST_L0_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (req_valid && priv_lvl == 2'd0) |=> (rsp_kind == 3'd1)); // R1
  AST_HYP_FIRST: assert property (@(posedge clk) disable iff (rst)
    (req_valid && priv_lvl == 2'd1 && l2_on64 && hyp_trap) |=> (rsp_kind == 3'd2)); // R2
  AST_TOP_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && priv_lvl == 2'd3) |=> (rsp_kind == 3'd0)); // R6
  AST_CLASS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind != 3'd2 && rsp_kind != 3'd3) |-> (rsp_class == '0)); // R7
  AST_REDIR_OFF: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == 3'd4) |-> (rsp_mem_off == REDIR_OFF)); // R4
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R8
  AST_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rsp_reg_wr && rsp_mem_wr)); // R9
  AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (rsp_reg_wr || rsp_mem_wr) |-> rsp_valid); // R9

endmodule

// File: tb/sim_priv_acc_gate.sv
module sim_priv_acc_gate;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  priv_lvl = 2'd0;
  logic        l2_on64 = 1'b0;
  logic        l3_on64 = 1'b0;
  logic        hyp_trap = 1'b0;
  logic        nonsecure = 1'b0;
  logic [1:0]  owner_ctl = 2'd0;
  logic [2:0]  nv_ctl = 3'd0;
  logic        rsp_valid;
  logic [2:0]  rsp_kind;
  logic [5:0]  rsp_class;
  logic [11:0] rsp_mem_off;
  logic        rsp_reg_wr;
  logic        rsp_mem_wr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [2:0]  kind;
    logic [5:0]  cls;
    logic [11:0] off;
    logic        rw;
    logic        mw;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #4 clk = ~clk;

  priv_acc_gate u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .priv_lvl(priv_lvl), .l2_on64(l2_on64), .l3_on64(l3_on64),
    .hyp_trap(hyp_trap), .nonsecure(nonsecure), .owner_ctl(owner_ctl),
    .nv_ctl(nv_ctl), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_class(rsp_class), .rsp_mem_off(rsp_mem_off),
    .rsp_reg_wr(rsp_reg_wr), .rsp_mem_wr(rsp_mem_wr)
  );

  function automatic exp_t model(input logic [1:0] lv, input logic l2, input logic l3,
                                 input logic hy, input logic ns, input logic [1:0] ow,
                                 input logic [2:0] nv, input logic wr);
    exp_t e;
    logic mon;
    mon = l3 && (ns ? (ow != 2'b11) : (ow != 2'b01));
    e.cls = 6'h00; e.off = 12'h000;
    if (lv == 2'd0) begin
      e.kind = 3'd1; e.tag = "R1/R7";
    end else if (lv == 2'd3) begin
      e.kind = 3'd0; e.tag = "R6/R7";
    end else if (lv == 2'd2) begin
      if (mon) begin e.kind = 3'd3; e.cls = 6'h18; e.tag = "R3/R5/R7"; end
      else     begin e.kind = 3'd0; e.tag = "R5/R7"; end
    end else begin
      if (l2 && hy)               begin e.kind = 3'd2; e.cls = 6'h18; e.tag = "R2/R7"; end
      else if (mon)               begin e.kind = 3'd3; e.cls = 6'h18; e.tag = "R3/R7"; end
      else if (l2 && nv[2] && nv[0]) begin e.kind = 3'd4; e.off = 12'h838; e.tag = "R4/R7"; end
      else                        begin e.kind = 3'd0; e.tag = "R4/R7"; end
    end
    e.rw = wr && (e.kind == 3'd0);
    e.mw = wr && (e.kind == 3'd4);
    if (wr) e.tag = {e.tag, "/R9"};
    return e;
  endfunction

  task automatic send(input logic [1:0] lv, input logic l2, input logic l3,
                      input logic hy, input logic ns, input logic [1:0] ow,
                      input logic [2:0] nv, input logic wr);
    @(negedge clk);
    priv_lvl = lv; l2_on64 = l2; l3_on64 = l3; hyp_trap = hy;
    nonsecure = ns; owner_ctl = ow; nv_ctl = nv; req_write = wr;
    req_valid = 1'b1;
    q.push_back(model(lv, l2, l3, hy, ns, ow, nv, wr));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: sample a quarter period after the rising edge.
  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      if (rsp_valid) begin
        if (q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R8: rsp_valid=1 with nothing pending, expected 0");
        end else begin
          exp_t e;
          e = q.pop_front();
          n_cmp++;
          if (rsp_kind !== e.kind || rsp_class !== e.cls || rsp_mem_off !== e.off ||
              rsp_reg_wr !== e.rw || rsp_mem_wr !== e.mw) begin
            n_bad++;
            $display("FAIL %s: kind=%0d cls=%h off=%h rw=%b mw=%b, expected kind=%0d cls=%h off=%h rw=%b mw=%b",
                     e.tag, rsp_kind, rsp_class, rsp_mem_off, rsp_reg_wr, rsp_mem_wr,
                     e.kind, e.cls, e.off, e.rw, e.mw);
          end
        end
      end else if (q.size() != 0) begin
        n_cmp++; n_bad++;
        void'(q.pop_front());
        $display("FAIL R8: rsp_valid=0 with a request due, expected 1");
      end
      if (!rsp_valid && (rsp_reg_wr || rsp_mem_wr)) begin
        n_cmp++; n_bad++;
        $display("FAIL R9: strobe rw=%b mw=%b without valid, expected 0", rsp_reg_wr, rsp_mem_wr);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs cleared while in reset
    n_cmp++;
    if ({rsp_valid, rsp_kind, rsp_class, rsp_mem_off, rsp_reg_wr, rsp_mem_wr} !== '0) begin
      n_bad++;
      $display("FAIL R10: outputs in reset %b, expected all zero",
               {rsp_valid, rsp_kind, rsp_class, rsp_mem_off, rsp_reg_wr, rsp_mem_wr});
    end
    rst = 1'b0;
    @(negedge clk);
    n_cmp++;
    if ({rsp_valid, rsp_kind, rsp_class, rsp_mem_off, rsp_reg_wr, rsp_mem_wr} !== '0) begin
      n_bad++;
      $display("FAIL R10: outputs after reset %b, expected all zero",
               {rsp_valid, rsp_kind, rsp_class, rsp_mem_off, rsp_reg_wr, rsp_mem_wr});
    end

    // Exhaustive sweep of every request combination, in bursts with gaps (R8).
    for (int c = 0; c < 4096; c++) begin
      logic [11:0] v;
      v = 12'(c);
      send(v[1:0], v[2], v[3], v[4], v[5], v[7:6], v[10:8], v[11]);
      if ((c % 97) == 96) idle(1 + (c % 3));
    end
    idle(4);

    // A lone request after idle, then silence: one pulse only (R8).
    send(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 3'b111, 1'b1);
    idle(5);
    n_cmp++;
    if (q.size() != 0 || rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R8: pending=%0d valid=%b at end, expected 0 and 0", q.size(), rsp_valid);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule